// File: doc/BRIEF.md
# Masked Breakpoint Address Comparator

This block belongs to an on-chip debug unit. It observes every CPU bus cycle and raises a registered one-clock pulse when the cycle hits a programmed breakpoint. A bus cycle is made of:

- the 16-bit address;
- a flag that says whether the access falls in the paged program window;
- the 6-bit page value;
- the read/write direction;
- the 16-bit data;
- a valid strobe.

There are two comparators, A and B. Each holds a compare address, a compare page, a two-bit byte mask and a direction qualifier. In paged accesses the address compare covers 20 bits: the page followed by address bits 13..0. In other accesses it covers the 16-bit address.

The mask code is written high:low. It selects one of three kinds of match:

- a full compare;
- a 256-byte window, where the low byte is ignored;
- a whole 16 KB page, where only the page value is compared.

The code 1:0 is not allowed and is forced to a full compare.

In data-qualified ("full") mode, comparator B compares the data bus against its stored value, with per-byte masks. The combined breakpoint then needs both A and B in the same cycle. In the normal mode the combined breakpoint is the OR of the two comparators. Software programs the comparators through a single write port.

Top module: `bkpt_cmp_top`

## Requirements
- R1: When `bus_paged` is 1, an address compare with mask code 0:0 matches only if `bus_page` equals the stored page and `bus_addr[13:0]` equals the stored address bits 13..0; `bus_addr[15:14]` has no effect.
- R2: When `bus_paged` is 0, an address compare uses all 16 address bits and `bus_page` has no effect.
- R3: Mask code high:low = 0:1 ignores the low address byte, so any address in the same 256-byte range matches. In paged accesses the page and address bits 13..8 are still compared.
- R4: Mask code 1:1 compares only the page value. Any paged access to the stored page matches, and a non-paged access never matches.
- R5: Mask code 1:0 behaves exactly like a full compare (0:0).
- R6: With the direction enable at 0, both reads and writes match. With it at 1, direction value 0 matches only writes (`bus_rd`=0) and value 1 matches only reads (`bus_rd`=1).
- R7: In full mode, `hit_b` reports a data compare of `bus_data` against comparator B's stored address value. B's mask high bit masks data bits 15..8 and its mask low bit masks bits 7..0, independently of each other. B's direction bits have no effect in this mode.
- R8: In full mode, `hit_bkpt` is 1 only when `hit_a` and `hit_b` are both 1. In normal mode, `hit_bkpt` equals `hit_a` OR `hit_b`.
- R9: The outputs are registered. A hit appears in the clock after the edge that sampled a bus cycle with `bus_valid`=1, and it lasts exactly one clock per valid cycle. A cycle with `bus_valid`=0 produces no hit.
- R10: A synchronous reset (`rst_n`=0 at a clock edge) clears the outputs and every stored address, page, mask, direction and mode bit, so all compare values read as zero afterwards.
- R11: A write with `cfg_we`=1 at a clock edge takes effect for the bus cycle sampled at the next edge. The register selected by `cfg_sel` is:
  - 0: A address (16 bits);
  - 1: A page (`cfg_wdata[5:0]`);
  - 2: B address or data value;
  - 3: B page;
  - 4: control word.

  The control word holds bit 0 = full mode; bits 1,2,3,4 = A mask-low, mask-high, direction enable, direction value; bits 5,6,7,8 = the same four fields for B.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Configuration register select |
| cfg_wdata | input | 16 | Configuration write data |
| bus_valid | input | 1 | Bus cycle valid strobe |
| bus_addr | input | 16 | CPU address |
| bus_paged | input | 1 | Access is inside the paged program window |
| bus_page | input | 6 | Current program page value |
| bus_rd | input | 1 | 1 = read cycle, 0 = write cycle |
| bus_data | input | 16 | Data bus value |
| hit_a | output | 1 | Comparator A hit pulse |
| hit_b | output | 1 | Comparator B hit pulse (data hit in full mode) |
| hit_bkpt | output | 1 | Combined breakpoint pulse |

## Verification
Every piece of internal state in this block is configuration. A wrong stored address, page, mask or mode bit therefore shows up only when a bus cycle probes it. It appears one clock after that probe as a missing or extra pulse on `hit_a`, `hit_b` or `hit_bkpt`.

The bench walks each mask code through both paged and non-paged cycles, with near-miss addresses on either side of the masked bits, so that a wrong mask decode or a wrong compare width changes the pulse seen on the very next clock. Direction, data-byte masking, the mode-dependent combine, and the clearing of the configuration by a mid-run reset are each probed by cycles whose expected result flips if the corresponding bit is wrong.

// File: rtl/bkpt_pkg.sv
// Package: shared widths, register selects and the per-comparator
// configuration record of the breakpoint comparator.
// Assumes a byte-sized mask granularity and exactly two comparators.
package bkpt_pkg;

    localparam int ADDR_W   = 16;
    localparam int PAGE_W   = 6;
    localparam int OFS_W    = 14;
    localparam int DATA_W   = 16;
    localparam int BYTE_W   = 8;
    localparam int NUM_CMP  = 2;
    localparam int SEL_W    = 3;
    localparam int CFG_W    = 16;
    localparam int KEY_W    = PAGE_W + OFS_W;
    localparam int CTL_SEL  = 2 * NUM_CMP;
    localparam int CTL_FULL = 0;
    localparam int CTL_PER  = 4;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [PAGE_W-1:0] page;
        logic              mask_hi;
        logic              mask_lo;
        logic              rw_en;
        logic              rw_val;
    } cmp_cfg_t;

endpackage

// File: rtl/bkpt_cfg_regs.sv
// Module: configuration register file for the comparators.
// Comparator k takes its address at select 2k and its page at select 2k+1.
// Its control fields sit in the control word at bit 1+4k and upward.
// Assumes a write takes effect at the clock edge that samples it.
module bkpt_cfg_regs
    import bkpt_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cfg_we,
    input  logic [SEL_W-1:0]             cfg_sel,
    input  logic [CFG_W-1:0]             cfg_wdata,
    output cmp_cfg_t [NUM_CMP-1:0]       cfg_o,
    output logic                         full_o
);

    cmp_cfg_t [NUM_CMP-1:0] cfg_q;
    logic                   full_q;

    genvar k;
    generate
        for (k = 0; k < NUM_CMP; k++) begin : g_cmp
            localparam int ADR_SEL = 2 * k;
            localparam int PG_SEL  = 2 * k + 1;
            localparam int BASE    = CTL_FULL + 1 + CTL_PER * k;

            // Purpose: hold one comparator's address, page, mask and direction fields.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    cfg_q[k] <= '0;
                end else if (cfg_we) begin
                    if (cfg_sel == SEL_W'(ADR_SEL))
                        cfg_q[k].addr <= cfg_wdata[ADDR_W-1:0];
                    if (cfg_sel == SEL_W'(PG_SEL))
                        cfg_q[k].page <= cfg_wdata[PAGE_W-1:0];
                    if (cfg_sel == SEL_W'(CTL_SEL)) begin
                        cfg_q[k].mask_lo <= cfg_wdata[BASE];
                        cfg_q[k].mask_hi <= cfg_wdata[BASE+1];
                        cfg_q[k].rw_en   <= cfg_wdata[BASE+2];
                        cfg_q[k].rw_val  <= cfg_wdata[BASE+3];
                    end
                end
            end
        end
    endgenerate

    // Purpose: hold the full-mode (data-qualified) selector.
    always_ff @(posedge clk) begin
        if (!rst_n)
            full_q <= 1'b0;
        else if (cfg_we && cfg_sel == SEL_W'(CTL_SEL))
            full_q <= cfg_wdata[CTL_FULL];
    end

    assign cfg_o  = cfg_q;
    assign full_o = full_q;

endmodule

// File: rtl/bkpt_addr_match.sv
// Module: one address comparator with byte mask and direction qualifier.
// Paged access: compare {page, addr[13:0]}. Non-paged access: compare addr[15:0].
// Mask 1:0 is forced to a full compare. Mask 1:1 compares the page only, so it
// cannot hit on a non-paged access.
// Assumes the mask applies to the two bytes below the page field.
module bkpt_addr_match
    import bkpt_pkg::*;
(
    input  cmp_cfg_t          cfg,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_paged,
    input  logic [PAGE_W-1:0] bus_page,
    input  logic              bus_rd,
    output logic              addr_hit,
    output logic              rw_ok
);

    localparam int HI_W = ADDR_W - BYTE_W;
    localparam int PH_W = OFS_W - BYTE_W;

    logic ign_hi;
    logic ign_lo;
    logic page_eq;
    logic phi_eq;
    logic hi_eq;
    logic lo_eq;
    logic paged_hit;
    logic flat_hit;

    // Purpose: decode the mask code; the high mask bit counts only when the low bit is set.
    always_comb begin
        ign_lo = cfg.mask_lo;
        ign_hi = cfg.mask_lo & cfg.mask_hi;
    end

    // Purpose: per-field equality for both compare widths.
    always_comb begin
        page_eq = (bus_page == cfg.page);
        phi_eq  = (bus_addr[OFS_W-1:BYTE_W] == cfg.addr[OFS_W-1:BYTE_W]);
        hi_eq   = (bus_addr[ADDR_W-1:BYTE_W] == cfg.addr[ADDR_W-1:BYTE_W]);
        lo_eq   = (bus_addr[BYTE_W-1:0] == cfg.addr[BYTE_W-1:0]);
    end

    // Purpose: combine fields per access kind; page-only mode needs a paged access.
    always_comb begin
        paged_hit = page_eq & (ign_hi | phi_eq) & (ign_lo | lo_eq);
        flat_hit  = ~ign_hi & hi_eq & (ign_lo | lo_eq);
        addr_hit  = bus_paged ? paged_hit : flat_hit;
    end

    // Purpose: direction qualifier; value 1 selects reads, value 0 selects writes.
    always_comb begin
        rw_ok = ~cfg.rw_en | (cfg.rw_val == bus_rd);
    end

    // Width sanity: offset must hold the high-byte part used in paged compares.
    if (PH_W < 1 || HI_W < 1) begin : g_bad_width
        $error("bkpt_addr_match: bad width split");
    end

endmodule

// File: rtl/bkpt_data_match.sv
// Module: data comparator used by comparator B in full mode.
// Each byte of the data bus is compared against the stored value. A set mask
// bit removes that byte from the compare; the high mask covers the upper byte,
// the low mask the lower byte.
// Assumes DATA_W is a whole number of bytes and holds two bytes.
module bkpt_data_match
    import bkpt_pkg::*;
(
    input  logic [DATA_W-1:0] ref_val,
    input  logic              mask_hi,
    input  logic              mask_lo,
    input  logic [DATA_W-1:0] bus_data,
    output logic              data_hit
);

    localparam int NBYTES = DATA_W / BYTE_W;

    logic [NBYTES-1:0] byte_ok;
    logic [NBYTES-1:0] byte_ign;

    assign byte_ign = {mask_hi, mask_lo};

    genvar b;
    generate
        for (b = 0; b < NBYTES; b++) begin : g_byte
            // Purpose: one byte lane compare, overridden by its mask.
            always_comb begin
                byte_ok[b] = byte_ign[b] |
                    (bus_data[b*BYTE_W +: BYTE_W] == ref_val[b*BYTE_W +: BYTE_W]);
            end
        end
    endgenerate

    assign data_hit = &byte_ok;

endmodule

// File: rtl/bkpt_cmp_top.sv
// Module: masked breakpoint comparator, top level.
// Samples one bus cycle per clock when bus_valid is high and reports registered
// hit pulses one clock later. Normal mode: two address comparators, combined
// by OR. Full mode: A on address, B on data, combined by AND.
// Assumes the bus cycle inputs are stable and synchronous to clk.
module bkpt_cmp_top
    import bkpt_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [SEL_W-1:0]     cfg_sel,
    input  logic [CFG_W-1:0]     cfg_wdata,
    input  logic                 bus_valid,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_paged,
    input  logic [PAGE_W-1:0]    bus_page,
    input  logic                 bus_rd,
    input  logic [DATA_W-1:0]    bus_data,
    output logic                 hit_a,
    output logic                 hit_b,
    output logic                 hit_bkpt
);

    cmp_cfg_t [NUM_CMP-1:0] cfg_q;
    cmp_cfg_t               a_cfg;
    logic                   full_mode;
    logic [NUM_CMP-1:0]     adr_hit;
    logic [NUM_CMP-1:0]     dir_ok;
    logic                   dat_hit;
    logic                   raw_a;
    logic                   raw_b;
    logic                   raw_k;

    bkpt_cfg_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .cfg_o     (cfg_q),
        .full_o    (full_mode)
    );

    genvar k;
    generate
        for (k = 0; k < NUM_CMP; k++) begin : g_amatch
            bkpt_addr_match u_am (
                .cfg       (cfg_q[k]),
                .bus_addr  (bus_addr),
                .bus_paged (bus_paged),
                .bus_page  (bus_page),
                .bus_rd    (bus_rd),
                .addr_hit  (adr_hit[k]),
                .rw_ok     (dir_ok[k])
            );
        end
    endgenerate

    bkpt_data_match u_dm (
        .ref_val  (cfg_q[1].addr),
        .mask_hi  (cfg_q[1].mask_hi),
        .mask_lo  (cfg_q[1].mask_lo),
        .bus_data (bus_data),
        .data_hit (dat_hit)
    );

    assign a_cfg = cfg_q[0];

    // Purpose: per-comparator qualified hits and the mode-dependent combine.
    always_comb begin
        raw_a = adr_hit[0] & dir_ok[0];
        raw_b = full_mode ? dat_hit : (adr_hit[1] & dir_ok[1]);
        raw_k = full_mode ? (raw_a & raw_b) : (raw_a | raw_b);
    end

    // Purpose: register the hit pulses, gated by the bus valid strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_a    <= 1'b0;
            hit_b    <= 1'b0;
            hit_bkpt <= 1'b0;
        end else begin
            hit_a    <= bus_valid & raw_a;
            hit_b    <= bus_valid & raw_b;
            hit_bkpt <= bus_valid & raw_k;
        end
    end

endmodule

// File: rtl/bkpt_cmp_chk.sv
// Module: assertion checker for bkpt_cmp_top, attached by bind.
module bkpt_cmp_chk (
    input logic clk,
    input logic rst_n,
    input logic bus_valid,
    input logic bus_paged,
    input logic bus_rd,
    input logic full_mode,
    input logic a_mask_hi,
    input logic a_mask_lo,
    input logic a_rw_en,
    input logic a_rw_val,
    input logic hit_a,
    input logic hit_b,
    input logic hit_bkpt
);

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!hit_a && !hit_b && !hit_bkpt)); // R10

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_valid |=> (!hit_a && !hit_b && !hit_bkpt)); // R9

    AST_PAGE_ONLY_FLAT: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_paged && a_mask_hi && a_mask_lo) |=> !hit_a); // R4

    AST_DIR_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && a_rw_en && (a_rw_val != bus_rd)) |=> !hit_a); // R6

    AST_FULL_AND: assert property (@(posedge clk) disable iff (!rst_n)
        full_mode |=> (hit_bkpt == (hit_a && hit_b))); // R8

    AST_NORMAL_OR: assert property (@(posedge clk) disable iff (!rst_n)
        !full_mode |=> (hit_bkpt == (hit_a || hit_b))); // R8

endmodule

bind bkpt_cmp_top bkpt_cmp_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_valid (bus_valid),
    .bus_paged (bus_paged),
    .bus_rd    (bus_rd),
    .full_mode (full_mode),
    .a_mask_hi (a_cfg.mask_hi),
    .a_mask_lo (a_cfg.mask_lo),
    .a_rw_en   (a_cfg.rw_en),
    .a_rw_val  (a_cfg.rw_val),
    .hit_a     (hit_a),
    .hit_b     (hit_b),
    .hit_bkpt  (hit_bkpt)
);

// File: tb/bkpt_cmp_top_bench.sv
// Scoreboard bench: driver tasks push the expected outputs, and a monitor pops
// and compares them 2 ns after each rising edge.
module bkpt_cmp_top_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_sel = '0;
    logic [15:0] cfg_wdata = '0;
    logic        bus_valid = 1'b0;
    logic [15:0] bus_addr = '0;
    logic        bus_paged = 1'b0;
    logic [5:0]  bus_page = '0;
    logic        bus_rd = 1'b0;
    logic [15:0] bus_data = '0;
    logic        hit_a;
    logic        hit_b;
    logic        hit_bkpt;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    typedef struct {
        logic  a;
        logic  b;
        logic  k;
        string tag;
    } exp_t;

    exp_t sb[$];

    // shadow configuration
    logic [15:0] sa_addr, sb_addr;
    logic [5:0]  sa_page, sb_page;
    logic [8:0]  sctl;

    always #5 clk = ~clk;

    bkpt_cmp_top u_bkpt_cmp_top (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .bus_valid(bus_valid), .bus_addr(bus_addr),
        .bus_paged(bus_paged), .bus_page(bus_page), .bus_rd(bus_rd),
        .bus_data(bus_data), .hit_a(hit_a), .hit_b(hit_b), .hit_bkpt(hit_bkpt)
    );

    function automatic logic addr_model(logic [15:0] ca, logic [5:0] cp, logic ml,
                                        logic mh, logic [15:0] a, logic pg, logic [5:0] p);
        logic [19:0] key, ref_k, m20;
        logic [15:0] m16;
        if (!pg) begin
            if (ml && mh) return 1'b0;
            m16 = ml ? 16'hFF00 : 16'hFFFF;
            return ((a ^ ca) & m16) == 16'h0;
        end
        key   = {p, a[13:0]};
        ref_k = {cp, ca[13:0]};
        m20   = !ml ? 20'hFFFFF : (mh ? 20'hFC000 : 20'hFFF00);
        return ((key ^ ref_k) & m20) == 20'h0;
    endfunction

    function automatic logic dir_model(logic en, logic val, logic rd);
        if (!en) return 1'b1;
        return val ? rd : !rd;
    endfunction

    function automatic logic [15:0] ctl(logic full, logic aml, logic amh, logic aen,
                                        logic aval, logic bml, logic bmh, logic ben, logic bval);
        return {7'b0, bval, ben, bmh, bml, aval, aen, amh, aml, full};
    endfunction

    task automatic push(logic a, logic b, logic k, string tag);
        exp_t e;
        e.a = a; e.b = b; e.k = k; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic wr(logic [2:0] sel, logic [15:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d; bus_valid = 1'b0;
        case (sel)
            3'd0: sa_addr = d;
            3'd1: sa_page = d[5:0];
            3'd2: sb_addr = d;
            3'd3: sb_page = d[5:0];
            3'd4: sctl = d[8:0];
            default: ;
        endcase
        push(1'b0, 1'b0, 1'b0, "R11");
    endtask

    task automatic bus(logic [15:0] a, logic pg, logic [5:0] p, logic rd,
                       logic [15:0] d, logic v, string tag);
        logic ra, rb, rk, full;
        @(negedge clk);
        cfg_we = 1'b0;
        bus_addr = a; bus_paged = pg; bus_page = p; bus_rd = rd;
        bus_data = d; bus_valid = v;
        full = sctl[0];
        ra = addr_model(sa_addr, sa_page, sctl[1], sctl[2], a, pg, p) &&
             dir_model(sctl[3], sctl[4], rd);
        if (full)
            rb = (((d ^ sb_addr) & {sctl[6] ? 8'h00 : 8'hFF, sctl[5] ? 8'h00 : 8'hFF}) == 16'h0);
        else
            rb = addr_model(sb_addr, sb_page, sctl[5], sctl[6], a, pg, p) &&
                 dir_model(sctl[7], sctl[8], rd);
        rk = full ? (ra && rb) : (ra || rb);
        push(v && ra, v && rb, v && rk, tag);
    endtask

    task automatic do_reset(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rst_n = 1'b0; cfg_we = 1'b0; bus_valid = 1'b0;
            push(1'b0, 1'b0, 1'b0, "R10");
        end
        sa_addr = '0; sb_addr = '0; sa_page = '0; sb_page = '0; sctl = '0;
        @(negedge clk);
        rst_n = 1'b1;
        push(1'b0, 1'b0, 1'b0, "R10");
    endtask

    // Monitor: compare the outputs just after each rising edge.
    always @(posedge clk) begin
        #2;
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            total++;
            if (hit_a !== e.a || hit_b !== e.b || hit_bkpt !== e.k) begin
                bad++;
                $display("FAIL %s: got a=%0b b=%0b k=%0b expected a=%0b b=%0b k=%0b",
                         e.tag, hit_a, hit_b, hit_bkpt, e.a, e.b, e.k);
            end
        end
    end

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL R9 watchdog: got running expected done");
            finish_run();
        end
    end

    initial begin
        do_reset(3);

        // R11: program A, normal mode, full mask
        wr(3'd0, 16'h4A37);
        wr(3'd1, 16'h0005);
        wr(3'd2, 16'h1234);
        wr(3'd3, 16'h0009);
        wr(3'd4, ctl(0, 0,0,0,0, 0,0,0,0));

        // R2: non-paged 16-bit compare, page ignored
        bus(16'h4A37, 0, 6'd3, 0, 16'h0, 1, "R2");
        bus(16'h4A38, 0, 6'd5, 0, 16'h0, 1, "R2");
        bus(16'h0A37, 0, 6'd5, 0, 16'h0, 1, "R2");
        // R1: paged 20-bit compare, addr[15:14] ignored
        bus(16'h0A37, 1, 6'd5, 1, 16'h0, 1, "R1");
        bus(16'hCA37, 1, 6'd5, 0, 16'h0, 1, "R1");
        bus(16'h0A37, 1, 6'd4, 0, 16'h0, 1, "R1");
        // R9: valid low gives nothing; back-to-back pulses
        bus(16'h4A37, 0, 6'd0, 0, 16'h0, 0, "R9");
        bus(16'h4A37, 0, 6'd0, 0, 16'h0, 1, "R9");
        bus(16'h4A37, 0, 6'd0, 0, 16'h0, 1, "R9");
        bus(16'h4A37, 0, 6'd0, 0, 16'h0, 0, "R9");
        // R8: normal-mode OR with B hit
        bus(16'h1234, 0, 6'd0, 0, 16'h0, 1, "R8");
        bus(16'h1234, 1, 6'd9, 0, 16'h0, 1, "R8");

        // R3: mask 0:1
        wr(3'd4, ctl(0, 1,0,0,0, 0,0,0,0));
        bus(16'h4AFF, 0, 6'd0, 0, 16'h0, 1, "R3");
        bus(16'h4B37, 0, 6'd0, 0, 16'h0, 1, "R3");
        bus(16'h0A00, 1, 6'd5, 0, 16'h0, 1, "R3");
        bus(16'h0B37, 1, 6'd5, 0, 16'h0, 1, "R3");
        // R5: mask 1:0 acts as full compare
        wr(3'd4, ctl(0, 0,1,0,0, 0,0,0,0));
        bus(16'h4A00, 0, 6'd0, 0, 16'h0, 1, "R5");
        bus(16'h4A37, 0, 6'd0, 0, 16'h0, 1, "R5");
        bus(16'h0A36, 1, 6'd5, 0, 16'h0, 1, "R5");
        // R4: mask 1:1 page only
        wr(3'd4, ctl(0, 1,1,0,0, 0,0,0,0));
        bus(16'h1234, 1, 6'd5, 0, 16'h0, 1, "R4");
        bus(16'h0A37, 1, 6'd6, 0, 16'h0, 1, "R4");
        bus(16'h4A37, 0, 6'd5, 0, 16'h0, 1, "R4");
        // R6: direction qualification
        wr(3'd4, ctl(0, 0,0,1,0, 0,0,0,0));
        bus(16'h4A37, 0, 6'd0, 0, 16'h0, 1, "R6");
        bus(16'h4A37, 0, 6'd0, 1, 16'h0, 1, "R6");
        wr(3'd4, ctl(0, 0,0,1,1, 0,0,0,0));
        bus(16'h4A37, 0, 6'd0, 0, 16'h0, 1, "R6");
        bus(16'h4A37, 0, 6'd0, 1, 16'h0, 1, "R6");
        wr(3'd4, ctl(0, 0,0,0,1, 0,0,1,0));
        bus(16'h4A37, 0, 6'd0, 1, 16'h0, 1, "R6");
        bus(16'h1234, 0, 6'd0, 1, 16'h0, 1, "R6");

        // R7/R8: full mode, B on data, B direction bits ignored
        wr(3'd2, 16'hBEEF);
        wr(3'd4, ctl(1, 0,0,0,0, 0,0,1,1));
        bus(16'h4A37, 0, 6'd0, 0, 16'hBEEF, 1, "R7");
        bus(16'h4A37, 0, 6'd0, 0, 16'hBEEE, 1, "R8");
        bus(16'h4A36, 0, 6'd0, 0, 16'hBEEF, 1, "R8");
        bus(16'hBEEF, 0, 6'd0, 0, 16'h0000, 1, "R7");
        wr(3'd4, ctl(1, 0,0,0,0, 1,0,0,0));
        bus(16'h4A37, 0, 6'd0, 0, 16'hBE00, 1, "R7");
        bus(16'h4A37, 0, 6'd0, 0, 16'hBF00, 1, "R7");
        wr(3'd4, ctl(1, 0,0,0,0, 0,1,0,0));
        bus(16'h4A37, 0, 6'd0, 1, 16'h00EF, 1, "R7");
        bus(16'h4A37, 0, 6'd0, 1, 16'h00EE, 1, "R7");
        wr(3'd4, ctl(1, 0,0,0,0, 1,1,0,0));
        bus(16'h0000, 0, 6'd0, 0, 16'h1357, 1, "R7");

        // R10: mid-run reset clears configuration
        do_reset(2);
        bus(16'h4A37, 0, 6'd0, 0, 16'h0, 1, "R10");
        bus(16'h0000, 0, 6'd0, 0, 16'h0, 1, "R10");
        bus(16'h0000, 1, 6'd0, 0, 16'h0, 1, "R10");

        // R11: a write is visible to the very next bus cycle
        wr(3'd0, 16'h7777);
        bus(16'h7777, 0, 6'd0, 0, 16'h0, 1, "R11");

        repeat (3) @(negedge clk);
        bus_valid = 1'b0;
        repeat (3) @(negedge clk);
        done = 1'b1;
        finish_run();
    end

endmodule